// File: doc/BRIEF.md
# Polled Serial Converter Read Controller

This block sits on the host side of a serial analog-to-digital converter that signals "sample ready" and shifts out its sample on one shared line. The controller polls that line. Once it has seen the line high and then low, it generates a serial clock and collects a 20-bit sample, one bit per clock pulse, most significant bit first. It then presents the sample with a one-cycle valid strobe.

The number of clock pulses per read is selectable. The base mode issues exactly 20 pulses. The second mode adds one pulse, which drives the line high so that a stale low data bit is not read as a ready flag on the next poll. The third mode issues 24 pulses and discards the four trailing bits, which are normally ones. If a trailing bit reads low, the converter has already published a new sample before the read finished, and the block reports an overrun.

The high and low phases of the generated clock each last a programmable number of system clocks. The line is brought in through a synchronizer. Each bit is taken at the falling edge of the generated clock, and the falling-edge strobe is delayed to match the synchronizer latency, so every bit is sampled half a period after the rising edge that launched it.

Top module: `serial_adc_reader`

## Requirements
- R1: A read starts only while `enable` is high and the synchronized line is low; with `enable` low no clock pulse is issued.
- R2: `sclk` idles low; during a read each high phase and each low phase lasts `half_period` system clocks, a value of 0 acting as 1.
- R3: The first bit captured in a read lands in `sample[19]` and the last of the 20 data bits in `sample[0]`.
- R4: Each bit is the line value at the falling edge of `sclk`, for any `half_period` of 1 or more, given the line changes just after the rising edge.
- R5: The number of `sclk` pulses per read follows `mode`: 2'b00 gives 20, 2'b01 gives 21, 2'b10 gives 24, 2'b11 gives 20.
- R6: `sample_valid` is high for exactly one system clock per read, after the 20th bit is captured, even while trailing pulses are still being issued; `sample` holds its value between strobes.
- R7: Bits captured after the 20th never change `sample`.
- R8: In modes 2'b01 and 2'b10, each trailing bit captured low raises `overrun` for one system clock; `overrun` never rises in modes 2'b00 and 2'b11.
- R9: After a read completes, no new read starts until the synchronized line has been seen high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows polling and the start of reads |
| mode | input | 2 | Pulse-count selection, latched at the start of a read |
| half_period | input | HP_W (8) | System clocks per `sclk` phase, latched at the start of a read |
| sdata | input | 1 | Shared ready and serial data line from the converter |
| sclk | output | 1 | Generated serial clock |
| sample | output | DATA_W (20) | Last assembled sample |
| sample_valid | output | 1 | One-cycle strobe when `sample` is updated |
| overrun | output | 1 | One-cycle strobe per trailing bit seen low |

## Verification
The hardest situations to reach are the ones where the line stays low after a read. This happens in base mode when the final data bit is zero, and in overrun reads where the trailing bits come back low. In both cases the controller must not read again until it sees a high level. The bench's converter model leaves the line at the last driven level, so the stimulus creates both situations directly. It then checks over a long idle window that no pulse appears, and afterwards raises and lowers the line to confirm that the next read starts. Overrun is produced by having the model return zeros on the trailing pulses of the 21- and 24-pulse modes, and sampling at the falling edge is exercised with `half_period` set to 1.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    RD_WAIT_HIGH = 2'd0,
    RD_WAIT_LOW  = 2'd1,
    RD_SHIFT     = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    CM_BASE  = 2'b00,
    CM_PARK  = 2'b01,
    CM_FULL  = 2'b10,
    CM_SPARE = 2'b11
  } clk_mode_e;

  // Pulses issued for one read: base data width plus any tail.
  function automatic int unsigned pulse_total(input logic [1:0] m,
                                              input int unsigned base,
                                              input int unsigned tail);
    case (clk_mode_e'(m))
      CM_PARK: return base + 1;
      CM_FULL: return base + tail;
      default: return base;
    endcase
  endfunction

  // A phase length of zero behaves as one system clock.
  function automatic int unsigned phase_len(input int unsigned hp);
    return (hp == 0) ? 1 : hp;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int unsigned HP_W  = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  input  logic [HP_W-1:0]  half,
  output logic             sclk,
  output logic             fall_evt
);
  logic             busy;
  logic [HP_W-1:0]  ph_cnt;
  logic [HP_W-1:0]  half_q;
  logic [CNT_W-1:0] rises;
  logic [CNT_W-1:0] tot_q;
  logic             phase_end;
  logic             rise_evt;

  assign phase_end = (ph_cnt == half_q - HP_W'(1));
  assign fall_evt  = busy && sclk && phase_end;
  assign rise_evt  = busy && !sclk && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      ph_cnt <= '0;
      half_q <= HP_W'(1);
      rises  <= '0;
      tot_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk   <= 1'b1;
      ph_cnt <= '0;
      half_q <= half;
      rises  <= CNT_W'(1);
      tot_q  <= total;
    end else if (fall_evt) begin
      sclk   <= 1'b0;
      ph_cnt <= '0;
      if (rises == tot_q) busy <= 1'b0;
    end else if (rise_evt) begin
      sclk   <= 1'b1;
      ph_cnt <= '0;
      rises  <= rises + CNT_W'(1);
    end else if (busy) begin
      ph_cnt <= ph_cnt + HP_W'(1);
    end
  end

  // R1: a read is only launched while no pulse train is running
  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R2: the phase length handed in is never zero
  p_half_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (half != '0));
  // R5: no rising edge beyond the pulse count of the read
  p_no_extra_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (rises < tot_q));
  // R2: the clock holds its level between phase boundaries
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_end && !start) |=> $stable(sclk));
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DLY    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fall_evt,
  input  logic              din,
  input  logic [CNT_W-1:0]  total,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid,
  output logic              overrun,
  output logic              last_cap
);
  localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(DATA_W);

  logic [DLY-1:0]    fall_dly;
  logic              cap_evt;
  logic [CNT_W-1:0]  cap_cnt;
  logic [CNT_W-1:0]  tot_q;
  logic [DATA_W-1:0] shreg;
  logic              in_data;
  logic              in_tail;

  // Delay the falling-edge strobe by the synchronizer depth, so the bit
  // taken is the line level at the moment the clock fell.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fall_dly <= '0;
    else        fall_dly <= {fall_dly[DLY-2:0], fall_evt};

  assign cap_evt  = fall_dly[DLY-1];
  assign in_data  = (cap_cnt < DATA_CNT);
  assign in_tail  = !in_data;
  assign last_cap = cap_evt && (cap_cnt == tot_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt      <= '0;
      tot_q        <= '0;
      shreg        <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
      if (start) begin
        cap_cnt <= '0;
        tot_q   <= total;
        shreg   <= '0;
      end else if (cap_evt) begin
        cap_cnt <= cap_cnt + CNT_W'(1);
        if (in_data) shreg <= {shreg[DATA_W-2:0], din};
        if (cap_cnt == DATA_CNT - CNT_W'(1)) begin
          sample       <= {shreg[DATA_W-2:0], din};
          sample_valid <= 1'b1;
        end
        if (in_tail && !din) overrun <= 1'b1;
      end
    end
  end

  // R6: the valid strobe never lasts longer than one clock
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  // R6: the output word only moves together with the strobe
  p_sample_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample));
  // R7: the strobe only follows the capture of the last data bit
  p_valid_at_data_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (cap_cnt == DATA_CNT));
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int unsigned DATA_W      = 20,
  parameter int unsigned HP_W        = 8,
  parameter int unsigned FULL_TAIL   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [HP_W-1:0]   half_period,
  input  logic              sdata,
  output logic              sclk,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid,
  output logic              overrun
);
  import adc_rd_pkg::*;

  localparam int unsigned CNT_W = $clog2(DATA_W + FULL_TAIL + 1);

  rd_state_e        state;
  logic             line_s;
  logic             start;
  logic             fall_evt;
  logic             last_cap;
  logic [CNT_W-1:0] total_now;
  logic [HP_W-1:0]  half_eff;
  logic             long_q;

  assign total_now = CNT_W'(pulse_total(mode, DATA_W, FULL_TAIL));
  assign half_eff  = HP_W'(phase_len(int'(half_period)));
  assign start     = (state == RD_WAIT_LOW) && enable && !line_s;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sdata),
    .q    (line_s)
  );

  adc_rd_sclk_gen #(.HP_W(HP_W), .CNT_W(CNT_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .total   (total_now),
    .half    (half_eff),
    .sclk    (sclk),
    .fall_evt(fall_evt)
  );

  adc_rd_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DLY(SYNC_STAGES)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fall_evt    (fall_evt),
    .din         (line_s),
    .total       (total_now),
    .sample      (sample),
    .sample_valid(sample_valid),
    .overrun     (overrun),
    .last_cap    (last_cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RD_WAIT_HIGH;
      long_q <= 1'b0;
    end else begin
      case (state)
        RD_WAIT_HIGH: if (enable && line_s) state <= RD_WAIT_LOW;
        RD_WAIT_LOW: begin
          if (!enable) state <= RD_WAIT_HIGH;
          else if (start) begin
            state  <= RD_SHIFT;
            long_q <= (total_now > CNT_W'(DATA_W));
          end
        end
        RD_SHIFT: if (last_cap) state <= RD_WAIT_HIGH;
        default: state <= RD_WAIT_HIGH;
      endcase
    end
  end

  // R1: the generated clock is only ever high inside a read
  p_sclk_in_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (state == RD_SHIFT));
  // R9: entering a read always follows a low level seen on the line
  p_read_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == RD_SHIFT) |-> !$past(line_s));
  // R8: overrun only reported in modes that read trailing bits
  p_overrun_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> long_q);
  // R2: the clock rests low whenever no read is running
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RD_SHIFT) |-> !sclk);
endmodule

// File: tb/test_serial_adc_reader.sv
module test_serial_adc_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  half_period = 8'd2;
  logic        sdata = 1'b1;
  logic        sclk;
  logic [19:0] sample;
  logic        sample_valid;
  logic        overrun;

  int n_checks = 0;
  int n_fail   = 0;
  logic [19:0] exp_q[$];
  int rises = 0;
  int rises_at_valid = 0;
  int ovr_seen = 0;
  int valid_seen = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  bit prev_valid = 1'b0;

  always #10 clk = ~clk;

  serial_adc_reader i_serial_adc_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .half_period(half_period), .sdata(sdata), .sclk(sclk),
    .sample(sample), .sample_valid(sample_valid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge sclk) rises++;

  // Monitor: phase lengths, strobes and the scoreboard comparison.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) begin
        if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
        hi_run++;
      end else begin
        if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        lo_run++;
      end
      if (overrun) ovr_seen++;
      if (sample_valid && prev_valid)
        check(1'b0, "R6", "valid longer than one clock", 2, 1);
      prev_valid = sample_valid;
      if (sample_valid) begin
        valid_seen++;
        rises_at_valid = rises;
        if (exp_q.size() == 0)
          check(1'b0, "R6", "unexpected valid strobe", 1, 0);
        else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(sample == e, "R3", "assembled sample", sample, e);
        end
      end
    end
  end

  function automatic int pulses(input logic [1:0] m);
    if (m == 2'b01) return 21;
    if (m == 2'b10) return 24;
    return 20;
  endfunction

  // Driver and converter model: raise, then lower the line, push the
  // expected word, and answer every rising edge with the next bit.
  task automatic do_read(input logic [19:0] w, input bit tail_low);
    int np;
    int hp;
    np = pulses(mode);
    hp = (half_period == 0) ? 1 : int'(half_period);
    sdata = 1'b1;
    repeat (6) @(negedge clk);
    rises = 0; ovr_seen = 0; valid_seen = 0;
    exp_q.push_back(w);
    sdata = 1'b0;
    for (int k = 1; k <= np; k++) begin
      @(posedge sclk);
      #3;
      if (k <= 20) sdata = w[20-k];
      else         sdata = tail_low ? 1'b0 : 1'b1;
    end
    repeat (4 * hp + 12) @(negedge clk);
    check(rises == np, "R5", "pulse count", rises, np);
    check(valid_seen == 1, "R6", "strobes per read", valid_seen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sclk == 1'b0 && sample_valid == 1'b0 && overrun == 1'b0 && sample == '0,
          "R2", "reset state", {sclk, sample_valid, overrun}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: disabled controller ignores a ready low
    sdata = 1'b0;
    repeat (60) @(negedge clk);
    check(rises == 0, "R1", "pulses while disabled", rises, 0);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    check(rises == 0, "R9", "pulses without a high first", rises, 0);

    // Base mode, several patterns and phase lengths
    mode = 2'b00; half_period = 8'd2;
    do_read(20'hA5C3B, 1'b0);
    check(ovr_seen == 0, "R8", "overrun in base mode", ovr_seen, 0);
    half_period = 8'd3;
    do_read(20'h80001, 1'b0);
    check(last_hi == 3 && last_lo == 3, "R2", "phase length 3",
          {last_hi, last_lo}, {32'd3, 32'd3});
    half_period = 8'd1;
    do_read(20'h5AA5F, 1'b0);   // R4: bits sampled at the falling edge, fastest clock
    check(last_hi == 1 && last_lo == 1, "R2", "phase length 1", {last_hi, last_lo},
          {32'd1, 32'd1});
    half_period = 8'd0;
    do_read(20'hFFFFF, 1'b0);
    check(last_hi == 1 && last_lo == 1, "R2", "zero phase acts as one",
          {last_hi, last_lo}, {32'd1, 32'd1});

    // R9: last bit zero leaves the line low; no new read may start
    half_period = 8'd2;
    do_read(20'h12344, 1'b0);
    rises = 0;
    repeat (80) @(negedge clk);
    check(rises == 0, "R9", "no restart on stale low", rises, 0);
    do_read(20'h00000, 1'b0);

    // Park mode: one extra pulse, line forced high
    mode = 2'b01;
    do_read(20'h3C3C3, 1'b0);
    check(ovr_seen == 0, "R8", "no overrun on high tail (21)", ovr_seen, 0);
    do_read(20'h7E7E7, 1'b1);
    check(ovr_seen == 1, "R8", "overrun on low tail (21)", ovr_seen, 1);

    // Full mode: four trailing bits, discarded (R7)
    mode = 2'b10; half_period = 8'd4;
    do_read(20'hC0FFE, 1'b0);
    check(ovr_seen == 0, "R8", "no overrun on high tail (24)", ovr_seen, 0);
    check(rises_at_valid < 24, "R6", "valid before tail ends", rises_at_valid, 23);
    half_period = 8'd2;
    do_read(20'h0F0F0, 1'b1);   // R7: low tail must not alter the sample
    check(ovr_seen == 4, "R8", "overrun per low tail bit (24)", ovr_seen, 4);

    // Spare encoding behaves as base mode
    mode = 2'b11;
    do_read(20'h13579, 1'b1);
    check(ovr_seen == 0, "R8", "overrun in spare mode", ovr_seen, 0);
    check(sample == 20'h13579, "R7", "sample held after read", sample, 20'h13579);

    check(exp_q.size() == 0, "R6", "all expected samples delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule